// File: doc/BRIEF.md
# Locked Indirect Debug Register Window

This block lets bus software reach wide internal debug registers through one 32-bit data register. Software first opens the window by writing a magic key to the key register. It then writes a control word that names the target register (a command code and a target-select bit), gives the register's width in bits, and asks for an access lock. It confirms the lock in the status register and moves the register's contents one 32-bit word at a time through the data register. The block counts the words, steps a word index, and drives a command/shift interface toward the target registers. A small register-file stub stands in for those registers.

The access lock is shared with a JTAG debug path. While the bus side holds it, JTAG requests are refused. The bus side gets it only while JTAG is not requesting. A lock can be released automatically after the last word of one register, or kept across several registers so that they form one atomic sequence. Writing a release code to the control register drops the lock at once, which aborts any sequence in progress.

Top module: `dbg_win_ctrl`

## Requirements
- R1: After reset the window is closed, no lock is held, the status word reads 0, the stub registers read 0 and `jtag_gnt_o` equals `jtag_req_i`.
- R2: The window is open only after the key register (word address 0) has been written with 0x0000EBAB. Writing any other value closes it. While the window is closed, control and data writes have no effect, and control and data reads return 0.
- R3: Control word fields are: register size minus one in [24:16], command in [15:8], target select in [7] and lock type in [1:0]. Reading the control register (word address 1) returns exactly those fields, with every other bit 0.
- R4: A control write that is granted the lock loads a remaining-word count of size_minus_one[8:5] + 1, which gives 1 to 16 words. The count is shown in status bits [12:8].
- R5: Lock type 01 acquires the lock and releases it automatically after the last data word.
- R6: Lock type 10 acquires the lock and keeps it after the last data word.
- R7: Lock type 00 or 11 releases the lock at once and clears the remaining count.
- R8: A control write with type 01 or 10 is granted the lock only if `jtag_req_i` is low in that cycle, or if the bus already holds the lock. When JTAG requests in the same cycle, JTAG wins. Status bit 0 shows whether the bus holds the lock.
- R9: `jtag_gnt_o` is high exactly when `jtag_req_i` is high and the bus does not hold the lock.
- R10: Status (word address 2) has bit 1 busy (lock held and words remain), bit 2 a sticky error and bit 3 window open. A data access made while the window is open but without the lock, or with no words remaining, is dropped (a read returns 0) and sets the error bit. Reading the status word clears the error bit.
- R11: Each accepted data word (word address 3) writes or reads word index 0, 1, ... of the stub register chosen by {target select, command[1:0]}. Registers with different target-select values are separate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Single-cycle bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word address: 0 key, 1 control, 2 status, 3 data |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the request |
| jtag_req_i | input | 1 | JTAG path requests or holds the debug registers |
| jtag_gnt_o | output | 1 | JTAG path is allowed to access the debug registers |

## Verification
Two functions can fall in the same clock cycle: a bus control write that asks for the lock, and a JTAG request. Either the JTAG request is raised in the very cycle of the control write, or it is already pending when the write arrives. The bench then checks that status bit 0 stays low and that `jtag_gnt_o` stays high. The reverse race is also provoked: a JTAG request is raised during the last data word of a type-01 sequence. The bench checks that the grant is low before that edge and high after it.

// File: rtl/dbg_win_pkg.sv
package dbg_win_pkg;
  localparam int DW         = 32;
  localparam int SIZE_W     = 9;
  localparam int WORD_SH    = 5;
  localparam int SIZE_LSB   = 16;
  localparam int CMD_LSB    = 8;
  localparam int TSEL_BIT   = 7;
  localparam int ST_LOCK    = 0;
  localparam int ST_BUSY    = 1;
  localparam int ST_ERR     = 2;
  localparam int ST_EN      = 3;
  localparam int ST_REM_LSB = 8;

  typedef enum logic [1:0] {
    REG_KEY  = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2,
    REG_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_ONCE = 2'd1,
    LK_KEEP = 2'd2,
    LK_REL  = 2'd3
  } lock_type_e;

  typedef struct packed {
    logic [SIZE_W-1:0] size_m1;
    logic [7:0]        cmd;
    logic              tsel;
    lock_type_e        ltype;
  } ctrl_t;
endpackage

// File: rtl/dbg_lock_arb.sv
module dbg_lock_arb
  import dbg_win_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_wr_i,
  input  lock_type_e ltype_i,
  input  logic       last_step_i,
  input  logic       jtag_req_i,
  output logic       grant_o,
  output logic       bus_lock_o,
  output logic       jtag_gnt_o
);
  logic lock_q, auto_q;
  logic acq, rel;

  assign acq        = ctrl_wr_i && (ltype_i == LK_ONCE || ltype_i == LK_KEEP);
  assign rel        = ctrl_wr_i && !acq;
  // JTAG wins a tie; an already held bus lock is simply re-armed
  assign grant_o    = acq && (lock_q || !jtag_req_i);
  assign bus_lock_o = lock_q;
  assign jtag_gnt_o = jtag_req_i && !lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      auto_q <= 1'b0;
    end else if (rel) begin
      lock_q <= 1'b0;
      auto_q <= 1'b0;
    end else if (grant_o) begin
      lock_q <= 1'b1;
      auto_q <= (ltype_i == LK_ONCE);
    end else if (last_step_i && auto_q) begin
      lock_q <= 1'b0;
      auto_q <= 1'b0;
    end
  end

  p_acq_when_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> !$past(jtag_req_i));
  p_release_now_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel |=> !lock_q);
  p_auto_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_step_i && auto_q && !ctrl_wr_i) |=> !lock_q);
  p_keep_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_step_i && lock_q && !auto_q && !ctrl_wr_i) |=> lock_q);
endmodule

// File: rtl/dbg_xfer_cnt.sv
module dbg_xfer_cnt #(
  parameter int IDX_W = 4,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] words_m1_i,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] rem_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic [CNT_W-1:0] rem_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      rem_q <= CNT_W'(words_m1_i) + CNT_W'(1);
      idx_q <= '0;
    end else if (clear_i) begin
      rem_q <= '0;
      idx_q <= '0;
    end else if (step_i) begin
      rem_q <= rem_q - CNT_W'(1);
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign rem_o  = rem_q;
  assign idx_o  = idx_q;
  assign last_o = (rem_q == CNT_W'(1));

  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> rem_q != '0);
endmodule

// File: rtl/dbg_reg_stub.sv
module dbg_reg_stub #(
  parameter int CMD_BITS = 2,
  parameter int IDX_W    = 4,
  parameter int DW       = 32,
  localparam int ENTRIES = 2 ** (CMD_BITS + 1),
  localparam int WORDS   = 2 ** IDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sh_valid_i,
  input  logic                sh_we_i,
  input  logic                sh_tsel_i,
  input  logic [CMD_BITS-1:0] sh_cmd_i,
  input  logic [IDX_W-1:0]    sh_idx_i,
  input  logic [DW-1:0]       sh_wdata_i,
  output logic [DW-1:0]       sh_rdata_o
);
  logic [DW-1:0]       mem_q [ENTRIES][WORDS];
  logic [CMD_BITS:0]   ent;

  assign ent        = {sh_tsel_i, sh_cmd_i};
  assign sh_rdata_o = mem_q[ent][sh_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++)
        for (int w = 0; w < WORDS; w++)
          mem_q[e][w] <= '0;
    end else if (sh_valid_i && sh_we_i) begin
      mem_q[ent][sh_idx_i] <= sh_wdata_i;
    end
  end
endmodule

// File: rtl/dbg_win_ctrl.sv
module dbg_win_ctrl
  import dbg_win_pkg::*;
#(
  parameter logic [DW-1:0] MAGIC         = 32'h0000_EBAB,
  parameter int            STUB_CMD_BITS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [1:0]    bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          jtag_req_i,
  output logic          jtag_gnt_o
);
  localparam int IDX_W = SIZE_W - WORD_SH;
  localparam int CNT_W = IDX_W + 1;

  reg_sel_e         reg_sel;
  logic             wr, rd;
  logic             en_q, err_q;
  ctrl_t            ctrl_q, ctrl_d;
  logic             ctrl_wr, data_acc, data_ok, data_bad, stat_rd;
  logic             grant, bus_lock, last;
  logic [CNT_W-1:0] rem;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    sh_rdata, stat_w, ctrl_w;

  assign reg_sel  = reg_sel_e'(bus_addr_i);
  assign wr       = bus_req_i && bus_we_i;
  assign rd       = bus_req_i && !bus_we_i;
  assign ctrl_wr  = wr && en_q && reg_sel == REG_CTRL;
  assign stat_rd  = rd && reg_sel == REG_STAT;
  assign data_acc = bus_req_i && en_q && reg_sel == REG_DATA;
  assign data_ok  = data_acc && bus_lock && rem != '0;
  assign data_bad = data_acc && !data_ok;

  assign ctrl_d.size_m1 = bus_wdata_i[SIZE_LSB +: SIZE_W];
  assign ctrl_d.cmd     = bus_wdata_i[CMD_LSB +: 8];
  assign ctrl_d.tsel    = bus_wdata_i[TSEL_BIT];
  assign ctrl_d.ltype   = lock_type_e'(bus_wdata_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      err_q  <= 1'b0;
      ctrl_q <= '0;
    end else begin
      if (wr && reg_sel == REG_KEY) en_q <= (bus_wdata_i == MAGIC);
      if (ctrl_wr) ctrl_q <= ctrl_d;
      if (data_bad)     err_q <= 1'b1;
      else if (stat_rd) err_q <= 1'b0;
    end
  end

  dbg_lock_arb u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_wr_i  (ctrl_wr),
    .ltype_i    (ctrl_d.ltype),
    .last_step_i(data_ok && last),
    .jtag_req_i (jtag_req_i),
    .grant_o    (grant),
    .bus_lock_o (bus_lock),
    .jtag_gnt_o (jtag_gnt_o)
  );

  dbg_xfer_cnt #(.IDX_W(IDX_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (grant),
    .words_m1_i(ctrl_d.size_m1[SIZE_W-1:WORD_SH]),
    .clear_i   (ctrl_wr && !grant),
    .step_i    (data_ok),
    .rem_o     (rem),
    .idx_o     (idx),
    .last_o    (last)
  );

  dbg_reg_stub #(.CMD_BITS(STUB_CMD_BITS), .IDX_W(IDX_W), .DW(DW)) u_stub (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sh_valid_i(data_ok),
    .sh_we_i   (bus_we_i),
    .sh_tsel_i (ctrl_q.tsel),
    .sh_cmd_i  (ctrl_q.cmd[STUB_CMD_BITS-1:0]),
    .sh_idx_i  (idx),
    .sh_wdata_i(bus_wdata_i),
    .sh_rdata_o(sh_rdata)
  );

  always_comb begin
    stat_w = '0;
    stat_w[ST_LOCK] = bus_lock;
    stat_w[ST_BUSY] = bus_lock && rem != '0;
    stat_w[ST_ERR]  = err_q;
    stat_w[ST_EN]   = en_q;
    stat_w[ST_REM_LSB +: CNT_W] = rem;
    ctrl_w = '0;
    ctrl_w[SIZE_LSB +: SIZE_W] = ctrl_q.size_m1;
    ctrl_w[CMD_LSB +: 8]       = ctrl_q.cmd;
    ctrl_w[TSEL_BIT]           = ctrl_q.tsel;
    ctrl_w[1:0]                = ctrl_q.ltype;
    unique case (reg_sel)
      REG_KEY:  bus_rdata_o = DW'(en_q);
      REG_CTRL: bus_rdata_o = en_q ? ctrl_w : '0;
      REG_STAT: bus_rdata_o = stat_w;
      REG_DATA: bus_rdata_o = (data_ok && !bus_we_i) ? sh_rdata : '0;
      default:  bus_rdata_o = '0;
    endcase
  end

  p_closed_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !en_q && reg_sel != REG_KEY) |=>
      ($stable(ctrl_q) && $stable(bus_lock) && $stable(rem)));
  p_load_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && grant) |=>
      rem == CNT_W'($past(bus_wdata_i[SIZE_LSB+WORD_SH +: IDX_W])) + CNT_W'(1));
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_bad |=> err_q);
  p_jtag_refused_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jtag_req_i && stat_w[ST_LOCK]) |-> !jtag_gnt_o);
endmodule

// File: tb/dbg_win_ctrl_test.sv
`timescale 1ns/1ps
module dbg_win_ctrl_test;
  localparam real HALF = 2.5;
  localparam int  WD_CYC = 200000;
  localparam logic [1:0] KY = 2'd0, CT = 2'd1, ST = 2'd2, DT = 2'd3;

  typedef struct packed {
    logic        we;
    logic [1:0]  rsel;
    logic [31:0] wdata;
    logic        chk;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VECS [NV] = '{
    '{1'b0, ST, 32'h0,         1'b1, 32'h0,         8'd1 },  // R1 idle status
    '{1'b1, CT, 32'h0000_0001, 1'b0, 32'h0,         8'd2 },  // R2 closed: ignored
    '{1'b0, CT, 32'h0,         1'b1, 32'h0,         8'd2 },
    '{1'b0, ST, 32'h0,         1'b1, 32'h0,         8'd2 },
    '{1'b1, KY, 32'h0000_EBAB, 1'b0, 32'h0,         8'd2 },
    '{1'b0, ST, 32'h0,         1'b1, 32'h8,         8'd2 },
    '{1'b1, CT, 32'h003F_0201, 1'b0, 32'h0,         8'd5 },  // 64 bits, type 01
    '{1'b0, CT, 32'h0,         1'b1, 32'h003F_0201, 8'd3 },  // R3
    '{1'b0, ST, 32'h0,         1'b1, 32'h20B,       8'd4 },  // R4
    '{1'b1, DT, 32'h1111_1111, 1'b0, 32'h0,         8'd11},
    '{1'b0, ST, 32'h0,         1'b1, 32'h10B,       8'd4 },
    '{1'b1, DT, 32'h2222_2222, 1'b0, 32'h0,         8'd11},
    '{1'b0, ST, 32'h0,         1'b1, 32'h008,       8'd5 },  // R5 auto release
    '{1'b1, DT, 32'h0000_0033, 1'b0, 32'h0,         8'd10},
    '{1'b0, ST, 32'h0,         1'b1, 32'h00C,       8'd10},  // R10 error set
    '{1'b0, ST, 32'h0,         1'b1, 32'h008,       8'd10},  // R10 cleared
    '{1'b1, CT, 32'h003F_0202, 1'b0, 32'h0,         8'd6 },  // type 10
    '{1'b0, DT, 32'h0,         1'b1, 32'h1111_1111, 8'd11},  // R11
    '{1'b0, DT, 32'h0,         1'b1, 32'h2222_2222, 8'd11},
    '{1'b0, ST, 32'h0,         1'b1, 32'h009,       8'd6 },  // R6 kept
    '{1'b0, DT, 32'h0,         1'b1, 32'h0,         8'd6 },
    '{1'b0, ST, 32'h0,         1'b1, 32'h00D,       8'd10},
    '{1'b1, CT, 32'h0,         1'b0, 32'h0,         8'd7 },  // type 00
    '{1'b0, ST, 32'h0,         1'b1, 32'h008,       8'd7 },  // R7
    '{1'b1, CT, 32'h001F_0102, 1'b0, 32'h0,         8'd7 },
    '{1'b0, ST, 32'h0,         1'b1, 32'h10B,       8'd7 },
    '{1'b1, CT, 32'h001F_0103, 1'b0, 32'h0,         8'd7 },  // type 11
    '{1'b0, ST, 32'h0,         1'b1, 32'h008,       8'd7 },
    '{1'b1, KY, 32'h1234_5678, 1'b0, 32'h0,         8'd2 },
    '{1'b0, ST, 32'h0,         1'b1, 32'h0,         8'd2 },
    '{1'b1, CT, 32'h001F_0101, 1'b0, 32'h0,         8'd2 },
    '{1'b0, ST, 32'h0,         1'b1, 32'h0,         8'd2 },
    '{1'b1, KY, 32'h0000_EBAB, 1'b0, 32'h0,         8'd2 },
    '{1'b1, CT, 32'h001F_0281, 1'b0, 32'h0,         8'd11},  // tsel 1
    '{1'b1, DT, 32'hAAAA_5555, 1'b0, 32'h0,         8'd11},
    '{1'b1, CT, 32'h001F_0201, 1'b0, 32'h0,         8'd11},
    '{1'b0, DT, 32'h0,         1'b1, 32'h1111_1111, 8'd11},
    '{1'b1, CT, 32'h001F_0281, 1'b0, 32'h0,         8'd11},
    '{1'b0, DT, 32'h0,         1'b1, 32'hAAAA_5555, 8'd11},
    '{1'b0, ST, 32'h0,         1'b1, 32'h008,       8'd5 },
    '{1'b1, CT, 32'h01FF_0001, 1'b0, 32'h0,         8'd4 },  // 512 bits
    '{1'b0, ST, 32'h0,         1'b1, 32'h100B,      8'd4 },
    '{1'b1, CT, 32'h0,         1'b0, 32'h0,         8'd7 },
    '{1'b0, ST, 32'h0,         1'b1, 32'h008,       8'd7 },
    '{1'b1, CT, 32'hFFFF_FF7C, 1'b0, 32'h0,         8'd3 },
    '{1'b0, CT, 32'h0,         1'b1, 32'h01FF_FF00, 8'd3 }   // R3 masked
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        jtag_req_i = 1'b0;
  logic        jtag_gnt_o;
  logic [31:0] rd_s;
  logic        gnt_s;
  int          n_run = 0, n_fail = 0;

  always #(HALF) clk_i = ~clk_i;

  dbg_win_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .jtag_req_i(jtag_req_i), .jtag_gnt_o(jtag_gnt_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample before the committing edge
  task automatic op(input logic req, input logic we, input logic [1:0] a,
                    input logic [31:0] d, input logic jr);
    @(negedge clk_i);
    bus_req_i = req; bus_we_i = we; bus_addr_i = a; bus_wdata_i = d; jtag_req_i = jr;
    #1;
    rd_s = bus_rdata_o; gnt_s = jtag_gnt_o;
    @(posedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; bus_req_i = 1'b0; jtag_req_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(WD_CYC * 2 * HALF);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    foreach (VECS[i]) begin
      op(1'b1, VECS[i].we, VECS[i].rsel, VECS[i].wdata, 1'b0);
      if (VECS[i].chk)
        check($sformatf("R%0d vec %0d", VECS[i].req, i), rd_s, VECS[i].exp);
    end

    // R1: reset restores idle state and clears the stub
    do_reset();
    op(1'b0, 1'b0, ST, 32'h0, 1'b1);
    check("R1 jtag grant after reset", 32'(gnt_s), 32'h1);
    op(1'b1, 1'b0, ST, 32'h0, 1'b1);
    check("R1 status after reset", rd_s, 32'h0);
    op(1'b1, 1'b1, KY, 32'h0000_EBAB, 1'b1);
    // R8: JTAG already requesting, bus lock refused
    op(1'b1, 1'b1, CT, 32'h001F_0201, 1'b1);
    op(1'b1, 1'b0, ST, 32'h0, 1'b1);
    check("R8 lock refused while jtag busy", rd_s, 32'h008);
    check("R9 jtag keeps grant", 32'(gnt_s), 32'h1);
    // R8: tie in the same cycle, JTAG wins
    op(1'b0, 1'b0, ST, 32'h0, 1'b0);
    op(1'b1, 1'b1, CT, 32'h001F_0202, 1'b1);
    op(1'b1, 1'b0, ST, 32'h0, 1'b1);
    check("R8 tie goes to jtag", rd_s, 32'h008);
    check("R9 jtag granted after tie", 32'(gnt_s), 32'h1);
    // R9: bus holds lock, JTAG refused until type 00
    op(1'b1, 1'b1, CT, 32'h001F_0202, 1'b0);
    op(1'b1, 1'b0, ST, 32'h0, 1'b1);
    check("R9 status lock held", rd_s, 32'h10B);
    check("R9 jtag refused", 32'(gnt_s), 32'h0);
    op(1'b1, 1'b1, CT, 32'h0, 1'b1);
    check("R9 jtag refused before release edge", 32'(gnt_s), 32'h0);
    op(1'b0, 1'b0, ST, 32'h0, 1'b1);
    check("R7 jtag granted after release", 32'(gnt_s), 32'h1);
    // R5: JTAG raised during last word of type 01
    op(1'b0, 1'b0, ST, 32'h0, 1'b0);
    op(1'b1, 1'b1, CT, 32'h001F_0101, 1'b0);
    op(1'b1, 1'b0, DT, 32'h0, 1'b1);
    check("R11 stub cleared by reset", rd_s, 32'h0);
    check("R5 jtag refused on last word", 32'(gnt_s), 32'h0);
    op(1'b0, 1'b0, ST, 32'h0, 1'b1);
    check("R5 jtag granted after auto release", 32'(gnt_s), 32'h1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule